// File: doc/BRIEF.md
# PCI Target Command Classifier and Beat Address Sequencer

This block sits behind the target side of a 32-bit PCI interface. On each address phase it takes the 4-bit bus command and the 32-bit address, decides whether the access is a memory read, a memory write, a configuration read or a configuration write, or whether it should be left alone. For memory commands it also reads the burst order from the two lowest address bits. From then on it presents the word address of each data phase, and advances that address whenever the surrounding bus logic accepts a beat.

Several command variants fold into the four basic access types. The wrap behaviour depends on which variant was used. The memory read-line variant always counts linearly. The write-and-invalidate variant always wraps inside the cache line. The cache-line length is supplied as a base-2 logarithm of the word count. It is sampled with the address. Handshake timing, parity, base-address matching and the data path belong to neighbouring logic.

Top module: `pci_tgt_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `claim`, `order_err` and all four strobes are low and `beat_addr` is zero.
- R2: Commands 0110, 1100 and 1110 are claimed as memory reads. `claim` rises and `mrd_stb` pulses for exactly the one cycle after the edge that captured the address phase.
- R3: Commands 0111 and 1111 are claimed as memory writes, with `claim` high and a one-cycle `mwr_stb` pulse at the same timing as R2.
- R4: Command 1010 is claimed with a `crd_stb` pulse and command 1011 with a `cwr_stb` pulse. The start address is {24'b0, ad[7:2], 2'b00}, ad[1:0] is ignored, and each beat advances bits [7:2] modulo 64 while the rest stay zero.
- R5: All other codes are never claimed. This includes the reserved codes 1000 and 1001 and the dual-address code 1101. For these codes no strobe fires and `claim` stays low until the next address phase. `beat_addr` holds {ad[31:2], 2'b00} and ignores beat acceptances.
- R6: For a memory command with ad[1:0] = 00 (other than 1111), the start address is {ad[31:2], 2'b00} and it increases by 4 on each accepted beat across the full 32 bits.
- R7: For commands 0110, 1100 and 0111 with ad[1:0] = 10, the burst wraps inside a line of 2^L words. L is `line_lg` saturated at 4. Bits above bit L+1 stay fixed, and the word index in bits [L+1:2] advances modulo 2^L.
- R8: Command 1110 always counts linearly as in R6, even when ad[1:0] = 10.
- R9: Command 1111 always wraps as in R7, whether ad[1:0] is 00 or 10.
- R10: A memory command with ad[1:0] = 01 or 11 sets `order_err` high from the cycle after capture until the next address phase. That access is not claimed and produces no strobe.
- R11: `beat_addr` changes only on an edge where `beat_accept` is high and the access is claimed. If `addr_valid` is high on the same edge, the new address phase wins and the sequence restarts from its start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_valid | input | 1 | High for the address-phase cycle |
| cmd | input | 4 | Bus command sampled with the address |
| ad | input | 32 | Address sampled in the address phase |
| line_lg | input | 3 | log2 of the cache-line length in words, sampled with the address |
| beat_accept | input | 1 | A data beat is accepted this cycle |
| claim | output | 1 | Current access is claimed |
| mrd_stb | output | 1 | One-cycle memory-read strobe |
| mwr_stb | output | 1 | One-cycle memory-write strobe |
| crd_stb | output | 1 | One-cycle configuration-read strobe |
| cwr_stb | output | 1 | One-cycle configuration-write strobe |
| order_err | output | 1 | Memory access used a reserved burst order |
| beat_addr | output | 32 | Byte address of the current data phase |

## Verification
The hardest case to reach is the wrap boundary. It depends on how the captured word index relates to the line length, so a burst has to start part-way through a line and run past the line's end. The bench therefore sweeps every command code against every burst-order encoding and several line lengths, including one above the saturation limit. The start word index changes from case to case, and each claimed burst is run for more beats than the longest line. Idle cycles inside bursts, and an address phase that coincides with a beat, cover the hold and restart rules.

// File: rtl/pci_tgt_seq_pkg.sv
// Shared types for the PCI target command classifier and beat sequencer.
// Assumes a 4-bit bus command and a 2-bit burst-order field.
package pci_tgt_seq_pkg;

    typedef enum logic [2:0] {
        ACC_NONE = 3'd0,
        ACC_MRD  = 3'd1,
        ACC_MWR  = 3'd2,
        ACC_CRD  = 3'd3,
        ACC_CWR  = 3'd4
    } acc_e;

    typedef enum logic [1:0] {
        ORD_LIN  = 2'd0,
        ORD_WRAP = 2'd1,
        ORD_RSVD = 2'd2
    } ord_e;

    typedef enum logic [1:0] {
        STEP_LIN  = 2'd0,
        STEP_WRAP = 2'd1,
        STEP_CFG  = 2'd2
    } step_e;

    typedef struct packed {
        acc_e kind;
        logic force_wrap;
        logic never_wrap;
    } cmd_info_t;

endpackage

// File: rtl/pts_cmd_decode.sv
// Classifies a bus command into an access kind plus wrap overrides.
// Purely combinational; assumes the command is valid in the address phase.
module pts_cmd_decode
    import pci_tgt_seq_pkg::*;
(
    input  logic [3:0] cmd,
    output cmd_info_t  info
);

    // Map each command code to its folded access kind and wrap policy.
    always_comb begin
        info = '{kind: ACC_NONE, force_wrap: 1'b0, never_wrap: 1'b0};
        case (cmd)
            4'b0110: info.kind = ACC_MRD;
            4'b1100: info.kind = ACC_MRD;
            4'b1110: begin
                info.kind       = ACC_MRD;
                info.never_wrap = 1'b1;
            end
            4'b0111: info.kind = ACC_MWR;
            4'b1111: begin
                info.kind       = ACC_MWR;
                info.force_wrap = 1'b1;
            end
            4'b1010: info.kind = ACC_CRD;
            4'b1011: info.kind = ACC_CWR;
            default: info.kind = ACC_NONE;
        endcase
    end

endmodule

// File: rtl/pts_order_decode.sv
// Decodes the burst-order field carried in the low two address bits.
// Combinational; only meaningful for memory commands.
module pts_order_decode
    import pci_tgt_seq_pkg::*;
(
    input  logic [1:0] lo,
    output ord_e       ord
);

    // 00 linear, 10 wrap, the odd encodings are reserved.
    always_comb begin
        case (lo)
            2'b00:   ord = ORD_LIN;
            2'b10:   ord = ORD_WRAP;
            default: ord = ORD_RSVD;
        endcase
    end

endmodule

// File: rtl/pts_addr_gen.sv
// Holds the beat address and advances it by one word per step.
// Assumes AW >= 8. The line length is given as log2 of words and is
// saturated at MAX_LG when it is loaded.
module pts_addr_gen
    import pci_tgt_seq_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LGW    = 3,
    parameter int MAX_LG = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [AW-1:0]  load_addr,
    input  step_e          load_mode,
    input  logic [LGW-1:0] load_lg,
    input  logic           step,
    output logic [AW-1:0]  addr
);

    localparam logic [LGW-1:0] LG_CAP = LGW'(MAX_LG);

    logic [AW-1:0]  addr_q;
    step_e          mode_q;
    logic [LGW-1:0] lg_q;
    logic [LGW-1:0] lg_sat;
    logic [AW-1:0]  wmask;
    logic [AW-1:0]  inc;
    logic [AW-1:0]  nxt;

    // Clamp the requested line length to the supported maximum.
    assign lg_sat = (load_lg > LG_CAP) ? LG_CAP : load_lg;

    // Build the mask covering the word-index bits of one cache line.
    generate
        for (genvar b = 0; b < AW; b++) begin : g_mask
            if (b < 2) begin : g_byte
                assign wmask[b] = 1'b0;
            end else begin : g_word
                assign wmask[b] = (b < int'(lg_q) + 2);
            end
        end
    endgenerate

    assign inc = addr_q + AW'(4);

    // Select the next address according to the captured step mode.
    always_comb begin
        case (mode_q)
            STEP_WRAP: nxt = (addr_q & ~wmask) | (inc & wmask);
            STEP_CFG:  nxt = {addr_q[AW-1:8], inc[7:0]};
            default:   nxt = inc;
        endcase
    end

    // Load on an address phase, otherwise advance on an accepted step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            mode_q <= STEP_LIN;
            lg_q   <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            mode_q <= load_mode;
            lg_q   <= lg_sat;
        end else if (step) begin
            addr_q <= nxt;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/pci_tgt_seq.sv
// PCI target command classifier and beat address sequencer.
// Captures command and address in the address phase, decides whether to
// claim, pulses one access strobe, and steps the beat address per accepted
// data beat. Assumes addr_valid is high for exactly the address-phase cycle.
module pci_tgt_seq
    import pci_tgt_seq_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LGW    = 3,
    parameter int MAX_LG = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           addr_valid,
    input  logic [3:0]     cmd,
    input  logic [AW-1:0]  ad,
    input  logic [LGW-1:0] line_lg,
    input  logic           beat_accept,
    output logic           claim,
    output logic           mrd_stb,
    output logic           mwr_stb,
    output logic           crd_stb,
    output logic           cwr_stb,
    output logic           order_err,
    output logic [AW-1:0]  beat_addr
);

    cmd_info_t     info;
    ord_e          ord;
    logic          is_mem;
    logic          is_cfg;
    logic          rsvd_ord;
    logic          take;
    logic          use_wrap;
    step_e         mode_sel;
    logic [AW-1:0] start_addr;
    logic          claim_q;
    logic          err_q;
    logic [3:0]    stb_q;
    logic [3:0]    stb_d;
    logic          step;

    pts_cmd_decode u_cmd (
        .cmd  (cmd),
        .info (info)
    );

    pts_order_decode u_ord (
        .lo  (ad[1:0]),
        .ord (ord)
    );

    // Combine command and order decode into claim, error and step mode.
    always_comb begin
        is_mem     = (info.kind == ACC_MRD) || (info.kind == ACC_MWR);
        is_cfg     = (info.kind == ACC_CRD) || (info.kind == ACC_CWR);
        rsvd_ord   = is_mem && (ord == ORD_RSVD);
        take       = (info.kind != ACC_NONE) && !rsvd_ord;
        use_wrap   = info.force_wrap || ((ord == ORD_WRAP) && !info.never_wrap);
        mode_sel   = is_cfg ? STEP_CFG : (use_wrap ? STEP_WRAP : STEP_LIN);
        start_addr = is_cfg ? {{(AW-8){1'b0}}, ad[7:2], 2'b00}
                            : {ad[AW-1:2], 2'b00};
        stb_d      = 4'b0000;
        if (take) begin
            case (info.kind)
                ACC_MRD: stb_d = 4'b0001;
                ACC_MWR: stb_d = 4'b0010;
                ACC_CRD: stb_d = 4'b0100;
                ACC_CWR: stb_d = 4'b1000;
                default: stb_d = 4'b0000;
            endcase
        end
    end

    // Hold claim and error until the next address phase; strobes last one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claim_q <= 1'b0;
            err_q   <= 1'b0;
            stb_q   <= 4'b0000;
        end else if (addr_valid) begin
            claim_q <= take;
            err_q   <= rsvd_ord;
            stb_q   <= stb_d;
        end else begin
            stb_q   <= 4'b0000;
        end
    end

    assign step = beat_accept && claim_q && !addr_valid;

    pts_addr_gen #(
        .AW     (AW),
        .LGW    (LGW),
        .MAX_LG (MAX_LG)
    ) u_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (addr_valid),
        .load_addr (start_addr),
        .load_mode (mode_sel),
        .load_lg   (line_lg),
        .step      (step),
        .addr      (beat_addr)
    );

    assign claim     = claim_q;
    assign order_err = err_q;
    assign mrd_stb   = stb_q[0];
    assign mwr_stb   = stb_q[1];
    assign crd_stb   = stb_q[2];
    assign cwr_stb   = stb_q[3];

endmodule

// File: rtl/pci_tgt_seq_chk.sv
// Property checker for pci_tgt_seq, attached with bind below.
// Observes ports only.
module pci_tgt_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          addr_valid,
    input logic [3:0]    cmd,
    input logic          beat_accept,
    input logic          claim,
    input logic          mrd_stb,
    input logic          mwr_stb,
    input logic          crd_stb,
    input logic          cwr_stb,
    input logic          order_err,
    input logic [AW-1:0] beat_addr
);

    logic any_stb;
    assign any_stb = mrd_stb | mwr_stb | crd_stb | cwr_stb;

    // R2
    stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mrd_stb, mwr_stb, crd_stb, cwr_stb}));

    // R3
    stb_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> claim);

    // R2
    stb_after_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> $past(addr_valid));

    // R5
    dual_never_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && cmd == 4'b1101) |=> !claim);

    // R5
    claim_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> $stable(claim));

    // R10
    err_not_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |-> !claim);

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid && !(beat_accept && claim)) |=> $stable(beat_addr));

    // R6
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_addr[1:0] == 2'b00);

endmodule

bind pci_tgt_seq pci_tgt_seq_chk #(.AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_valid  (addr_valid),
    .cmd         (cmd),
    .beat_accept (beat_accept),
    .claim       (claim),
    .mrd_stb     (mrd_stb),
    .mwr_stb     (mwr_stb),
    .crd_stb     (crd_stb),
    .cwr_stb     (cwr_stb),
    .order_err   (order_err),
    .beat_addr   (beat_addr)
);

// File: tb/pci_tgt_seq_tb.sv
// Sweeps all command codes, burst orders and several line lengths,
// computing expected strobes and beat addresses arithmetically.
module pci_tgt_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_valid = 1'b0;
    logic [3:0]  cmd = 4'h0;
    logic [31:0] ad = 32'h0;
    logic [2:0]  line_lg = 3'd0;
    logic        beat_accept = 1'b0;
    logic        claim, mrd_stb, mwr_stb, crd_stb, cwr_stb, order_err;
    logic [31:0] beat_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pci_tgt_seq dut_i (
        .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .cmd(cmd),
        .ad(ad), .line_lg(line_lg), .beat_accept(beat_accept),
        .claim(claim), .mrd_stb(mrd_stb), .mwr_stb(mwr_stb),
        .crd_stb(crd_stb), .cwr_stb(cwr_stb), .order_err(order_err),
        .beat_addr(beat_addr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected strobe vector {cwr,crd,mwr,mrd} from the command alone.
    function automatic logic [3:0] kind_of(input logic [3:0] c);
        case (c)
            4'b0110, 4'b1100, 4'b1110: return 4'b0001;
            4'b0111, 4'b1111:          return 4'b0010;
            4'b1010:                   return 4'b0100;
            4'b1011:                   return 4'b1000;
            default:                   return 4'b0000;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c, input logic [1:0] lo);
        logic [3:0] k;
        k = kind_of(c);
        if (k == 4'b0000) return "R5";
        if (k[2] || k[3]) return "R4";
        if (lo[0]) return "R10";
        if (c == 4'b1111) return "R9";
        if (c == 4'b1110) return "R8";
        if (lo == 2'b10) return "R7";
        return "R6";
    endfunction

    // Expected address after n accepted beats.
    function automatic logic [31:0] exp_addr(input logic [3:0] c, input logic [31:0] a,
                                             input int lg, input int n);
        logic [3:0] k;
        int L;
        logic [31:0] base;
        int idx;
        k = kind_of(c);
        if (k[2] || k[3]) return {24'h0, 6'((int'(a[7:2]) + n) % 64), 2'b00};
        if (k == 4'b0000 || a[0]) return {a[31:2], 2'b00};
        if (c == 4'b1111 || (a[1:0] == 2'b10 && c != 4'b1110)) begin
            L = 1 << ((lg > 4) ? 4 : lg);
            base = a & ~(32'(L * 4) - 32'd1);
            idx = int'(a[7:2]) % L;
            return base | 32'(((idx + n) % L) * 4);
        end
        return {a[31:2], 2'b00} + 32'(4 * n);
    endfunction

    task automatic phase(input logic [3:0] c, input logic [31:0] a, input logic [2:0] lg,
                         input logic with_beat);
        @(negedge clk);
        addr_valid = 1'b1; cmd = c; ad = a; line_lg = lg; beat_accept = with_beat;
        @(negedge clk);
        addr_valid = 1'b0; beat_accept = 1'b0;
    endtask

    initial begin
        int lgs[4] = '{0, 2, 4, 6};
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        check("R1", "claim", 32'(claim), 32'h0);
        check("R1", "strobes", 32'({cwr_stb, crd_stb, mwr_stb, mrd_stb}), 32'h0);
        check("R1", "order_err", 32'(order_err), 32'h0);
        check("R1", "beat_addr", beat_addr, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "claim after release", 32'(claim), 32'h0);

        for (int c = 0; c < 16; c++) begin
            for (int lo = 0; lo < 4; lo++) begin
                for (int li = 0; li < 4; li++) begin
                    logic [31:0] a;
                    logic [3:0] k;
                    logic claimed;
                    string r;
                    a = 32'h9E37_0000 ^ 32'(c * 32'h0101_1000) ^ 32'((c * 7 + lo * 3 + li * 5) << 2);
                    a[1:0] = 2'(lo);
                    k = kind_of(4'(c));
                    claimed = (k != 4'b0000) && !((k[0] || k[1]) && a[0]);
                    r = req_of(4'(c), 2'(lo));
                    phase(4'(c), a, 3'(lgs[li]), 1'b0);
                    // R2 R3 R4 R5 R10: decode result one cycle after capture
                    check(r, "claim", 32'(claim), 32'(claimed));
                    check(r, "strobes", 32'({cwr_stb, crd_stb, mwr_stb, mrd_stb}),
                          32'(claimed ? k : 4'b0000));
                    check("R10", "order_err", 32'(order_err),
                          32'((k[0] || k[1]) && a[0]));
                    check(r, "start addr", beat_addr, exp_addr(4'(c), a, lgs[li], 0));
                    for (int n = 1; n <= 18; n++) begin
                        @(negedge clk); beat_accept = 1'b1;
                        @(negedge clk); beat_accept = 1'b0;
                        check(r, "beat addr", beat_addr,
                              exp_addr(4'(c), a, lgs[li], claimed ? n : 0));
                        if (n == 1) begin
                            check(r, "strobe gone", 32'({cwr_stb, crd_stb, mwr_stb, mrd_stb}), 32'h0);
                            check("R5", "claim held", 32'(claim), 32'(claimed));
                        end
                        if (n == 5) begin
                            // R11: idle cycle holds the address
                            @(negedge clk);
                            check("R11", "idle hold", beat_addr,
                                  exp_addr(4'(c), a, lgs[li], claimed ? n : 0));
                        end
                    end
                    check("R10", "err held", 32'(order_err), 32'((k[0] || k[1]) && a[0]));
                end
            end
        end

        // R11: address phase coinciding with a beat restarts the sequence
        phase(4'b0111, 32'h0000_1000, 3'd2, 1'b0);
        @(negedge clk); beat_accept = 1'b1;
        @(negedge clk); beat_accept = 1'b0;
        phase(4'b0110, 32'h0000_2010, 3'd2, 1'b1);
        check("R11", "restart on phase", beat_addr, 32'h0000_2010);
        check("R2", "mrd after restart", 32'(mrd_stb), 32'h1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule